// File: doc/BRIEF.md
# Tile-Scaled BF16 to FP8 E4M3 Quantizer

This block takes a valid/ready stream of BF16 values and turns it into 8-bit E4M3 floating-point codes. Every run of `TILE_LEN` consecutive accepted inputs (128 by default) forms a tile, and all elements of a tile share one scale. The scale is always a power of two, 2^T, and only the signed integer T is carried. Each element is divided by 2^T and rounded to E4M3. Because the scale is a pure power of two, moving a tile to another power-of-two scale only changes exponent fields. Encoding a value that already lies on the tile's grid gives back exactly the same code.

A tile has to be complete before its largest magnitude is known, so the block holds whole tiles in two buffers used in ping-pong fashion. One tile is encoded and streamed out while the next is being filled, which sustains one element per cycle in each direction. Each output code carries the tile's scale exponent on a sideband, and a flag marks the first code of each tile.

Top module: `bf16_e4m3_tile_quantizer`

## Requirements
- R1: Each group of `TILE_LEN` consecutive accepted inputs forms one tile. Tiles and the elements inside them leave in arrival order. Every output code carries its tile's scale exponent on `out_scale_exp`. `out_first` is high exactly on the first code of each tile.
- R2: The scale exponent T is the smallest integer for which the tile's largest magnitude M satisfies M ≤ 448·2^T. It is a 9-bit two's-complement value covering -134 to 120.
- R3: Each code is laid out as bit 7 = sign, bits 6:3 = exponent E with bias 7, and bits 2:0 = mantissa M. A normal code (E ≥ 1) has magnitude (1+M/8)·2^(E-7), and a code with E = 0 has magnitude M·2^-9. The code is the representable magnitude nearest to |x|/2^T. When two codes are equally near, the one with an even mantissa (an even code) is chosen.
- R4: A scaled magnitude below 2^-6 becomes a subnormal code (E = 0) or zero, still rounded to nearest-even. The sign bit always follows the input sign, including when the result is zero.
- R5: No code has a magnitude above 448, so the codes 0x7F and 0xFF never appear.
- R6: A tile whose elements are all zero gets T = 0. Each of its codes is 0x00 or 0x80, following the input sign.
- R7: A BF16 input whose exponent field is 0 is treated as zero. It plays no part in the tile maximum and is encoded as signed zero.
- R8: An input equal to c·2^T, where c is a code magnitude and T is the tile's own scale exponent, is encoded exactly as code c. This makes re-quantizing with the same scale lossless.
- R9: After reset, `out_valid` is low and `in_ready` is high. No code of a tile is offered until all `TILE_LEN` of its elements have been accepted.
- R10: While `out_ready` is held high, a continuous input stream is accepted every cycle with no stall.
- R11: While `out_valid` is high and `out_ready` is low, the outputs hold steady. `in_ready` drops only when both buffers hold complete tiles that have not been output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can accept an element |
| in_data | input | 16 | BF16 input element |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Downstream accepts the code |
| out_code | output | 8 | E4M3 code |
| out_scale_exp | output | 9 | Signed tile scale exponent T |
| out_first | output | 1 | First code of a tile |

## Verification
The embedded assertions check, on every cycle, four properties:
- outputs hold still under backpressure;
- the reserved all-ones magnitude code never appears;
- inputs with a zero exponent field always leave as zero-magnitude codes;
- a new tile always starts with its first-code flag.

Only the bench scenarios can show that the numerical results are right: the chosen scale exponent at both ends of its range, nearest-even rounding on exact ties, and the subnormal range. The same holds for exact reproduction of on-grid values and for the absence of input stalls while the output runs freely. The bench checks these against a model that works with real numbers and searches every code.

// File: rtl/fp8q_pkg.sv
package fp8q_pkg;

    localparam int BF16_W  = 16;
    localparam int MAG_W   = 15;
    localparam int CODE_W  = 8;
    localparam int SCALE_W = 9;
    // 448 = 1.75 * 2^8: largest finite E4M3 magnitude
    localparam int MAXFIN_EXP = 8;
    localparam int BF16_BIAS  = 127;

    typedef logic [BF16_W-1:0]         bf16_t;
    typedef logic signed [SCALE_W-1:0] scale_t;

    // Magnitude with zero-exponent inputs flushed to zero.
    function automatic logic [MAG_W-1:0] flushed_mag(bf16_t x);
        if (x[14:7] == 8'd0) return '0;
        return x[14:0];
    endfunction

    // Smallest T with mag <= 448 * 2^T (power-of-two scale).
    // mag/448 = ((128+f)/224) * 2^(e-135); the fraction exceeds 1 only when f > 96.
    function automatic scale_t pow2_scale(logic [MAG_W-1:0] m);
        int t;
        if (m == '0) begin
            t = 0;
        end else begin
            t = int'(m[14:7]) - BF16_BIAS - MAXFIN_EXP + ((m[6:0] > 7'd96) ? 1 : 0);
        end
        return scale_t'(t);
    endfunction

endpackage

// File: rtl/tile_store.sv
module tile_store
    import fp8q_pkg::*;
#(
    parameter int TILE_LEN = 128,
    localparam int IDX_W = $clog2(TILE_LEN)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  bf16_t            wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output bf16_t            rd_data
);

    bf16_t bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        bf16_t mem [TILE_LEN];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_idx] <= wr_data;
            end
        end
        assign bank_rd[b] = mem[rd_idx];
    end

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/tile_max.sv
module tile_max
    import fp8q_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_fire,
    input  logic       in_first,
    input  bf16_t      in_word,
    output scale_t     tile_scale
);

    typedef struct packed {
        logic [MAG_W-1:0] run_max;
    } max_state_t;

    max_state_t max_d, max_q;
    logic [MAG_W-1:0] cur_mag;
    logic [MAG_W-1:0] cur_max;

    always_comb begin
        max_d   = max_q;
        cur_mag = flushed_mag(in_word);
        if (in_first || (cur_mag > max_q.run_max)) begin
            cur_max = cur_mag;
        end else begin
            cur_max = max_q.run_max;
        end
        if (in_fire) begin
            max_d.run_max = cur_max;
        end
        tile_scale = pow2_scale(cur_max);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
        end else begin
            max_q <= max_d;
        end
    end

    // R2: a nonzero tile maximum never yields a scale outside the legal range
    a_r2_scale_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> (tile_scale >= -9'sd134) && (tile_scale <= 9'sd120));

endmodule

// File: rtl/e4m3_encode.sv
module e4m3_encode
    import fp8q_pkg::*;
(
    input  bf16_t              in_word,
    input  scale_t             scale_exp,
    output logic [CODE_W-1:0]  code
);

    int          unb_exp;
    int          shamt;
    logic [7:0]  exp_f;
    logic [6:0]  frac;
    logic [6:0]  mag7;
    logic [6:0]  nrm;
    logic        round_up;
    logic [23:0] wide;
    logic [7:0]  keep;

    always_comb begin
        exp_f    = in_word[14:7];
        frac     = in_word[6:0];
        unb_exp  = int'(exp_f) - BF16_BIAS - int'(scale_exp);
        shamt    = 0;
        nrm      = '0;
        round_up = 1'b0;
        wide     = '0;
        keep     = '0;
        mag7     = '0;
        if (exp_f == 8'd0) begin
            mag7 = '0;
        end else if (unb_exp > MAXFIN_EXP) begin
            mag7 = 7'h7E;
        end else if (unb_exp >= -6) begin
            // normal: guard is frac[3], sticky is frac[2:0]
            nrm      = {4'(unb_exp + 7), frac[6:4]};
            round_up = frac[3] & ((|frac[2:0]) | frac[4]);
            mag7     = nrm + 7'(round_up);
        end else begin
            // subnormal: magnitude in units of 2^-9 is (128+f) * 2^(u+2)
            shamt = -(unb_exp + 2);
            if (shamt > 24) shamt = 24;
            wide     = {1'b1, frac, 16'd0} >> shamt;
            keep     = wide[23:16];
            round_up = wide[15] & ((|wide[14:0]) | keep[0]);
            mag7     = 7'(keep) + 7'(round_up);
        end
        code = {in_word[15], mag7};
    end

endmodule

// File: rtl/bf16_e4m3_tile_quantizer.sv
module bf16_e4m3_tile_quantizer
    import fp8q_pkg::*;
#(
    parameter int TILE_LEN = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [15:0]               in_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [7:0]                out_code,
    output logic signed [8:0]         out_scale_exp,
    output logic                      out_first
);

    localparam int IDX_W = $clog2(TILE_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TILE_LEN - 1);

    typedef struct packed {
        logic                         wr_bank;
        logic [IDX_W-1:0]             wr_idx;
        logic                         rd_bank;
        logic [IDX_W-1:0]             rd_idx;
        logic [1:0]                   full;
        logic [1:0][SCALE_W-1:0]      scale;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    logic   in_fire, out_fire, in_last, out_last;
    scale_t tile_scale;
    scale_t rd_scale;
    bf16_t  rd_data;

    tile_store #(.TILE_LEN(TILE_LEN)) u_store (
        .clk     (clk),
        .wr_en   (in_fire),
        .wr_bank (ctl_q.wr_bank),
        .wr_idx  (ctl_q.wr_idx),
        .wr_data (in_data),
        .rd_bank (ctl_q.rd_bank),
        .rd_idx  (ctl_q.rd_idx),
        .rd_data (rd_data)
    );

    tile_max u_max (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_fire    (in_fire),
        .in_first   (ctl_q.wr_idx == '0),
        .in_word    (in_data),
        .tile_scale (tile_scale)
    );

    assign rd_scale = $signed(ctl_q.scale[ctl_q.rd_bank]);

    e4m3_encode u_enc (
        .in_word   (rd_data),
        .scale_exp (rd_scale),
        .code      (out_code)
    );

    always_comb begin
        ctl_d     = ctl_q;
        in_ready  = !ctl_q.full[ctl_q.wr_bank];
        out_valid = ctl_q.full[ctl_q.rd_bank];
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
        in_last   = (ctl_q.wr_idx == LAST_IDX);
        out_last  = (ctl_q.rd_idx == LAST_IDX);

        if (in_fire) begin
            if (in_last) begin
                ctl_d.wr_idx                = '0;
                ctl_d.full[ctl_q.wr_bank]   = 1'b1;
                ctl_d.scale[ctl_q.wr_bank]  = tile_scale;
                ctl_d.wr_bank               = ~ctl_q.wr_bank;
            end else begin
                ctl_d.wr_idx = ctl_q.wr_idx + 1'b1;
            end
        end

        if (out_fire) begin
            if (out_last) begin
                ctl_d.rd_idx              = '0;
                ctl_d.full[ctl_q.rd_bank] = 1'b0;
                ctl_d.rd_bank             = ~ctl_q.rd_bank;
            end else begin
                ctl_d.rd_idx = ctl_q.rd_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_scale_exp = rd_scale;
    assign out_first     = (ctl_q.rd_idx == '0);

    // R11: a stalled output is held unchanged
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_code)
                                   && $stable(out_scale_exp) && $stable(out_first));

    // R5: the reserved all-ones magnitude never leaves the block
    a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_code[6:0] != 7'h7F);

    // R7: zero-exponent buffered words always encode as zero magnitude
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (rd_data[14:7] == 8'd0) |-> out_code[6:0] == 7'd0);

    // R1: after the last code of a tile the next offered code starts a tile
    a_r1_tile_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && out_last |=> !out_valid || out_first);

    // R9: output becomes valid only at the start of a complete tile
    a_r9_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_first);

endmodule

// File: tb/bf16_e4m3_tile_quantizer_bench.sv
`timescale 1ns/1ps
module bf16_e4m3_tile_quantizer_bench;

    localparam int TILE = 128;
    localparam int NEXP = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [15:0]       in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [7:0]        out_code;
    logic signed [8:0] out_scale_exp;
    logic              out_first;

    always #2.5 clk = ~clk;

    bf16_e4m3_tile_quantizer u_bf16_e4m3_tile_quantizer (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_code      (out_code),
        .out_scale_exp (out_scale_exp),
        .out_first     (out_first)
    );

    int        n_checks = 0;
    int        n_fail   = 0;
    int        stall_cnt = 0;
    bit        rdy_random = 1'b0;
    string     cur_req = "R1";
    logic [15:0] tile_in [TILE];
    logic [7:0]  exp_code  [NEXP];
    int          exp_scale [NEXP];
    int          exp_wr = 0;
    int          exp_rd = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, expv, expv);
        end
    endtask

    function automatic real p2(int k);
        return 2.0 ** real'(k);
    endfunction

    function automatic real bf16_val(logic [15:0] x);
        real v;
        if (x[14:7] == 8'd0) return 0.0;          // R7: flushed
        v = (1.0 + real'(x[6:0]) / 128.0) * p2(int'(x[14:7]) - 127);
        return x[15] ? -v : v;
    endfunction

    function automatic real code_val(logic [6:0] c);
        if (c[6:3] == 4'd0) return real'(c[2:0]) * p2(-9);
        return (1.0 + real'(c[2:0]) / 8.0) * p2(int'(c[6:3]) - 7);
    endfunction

    function automatic logic [15:0] grid_bf16(real v, bit s);
        int k = 0;
        int m;
        if (v == 0.0) return {s, 15'd0};
        while (v >= p2(k + 1)) k++;
        while (v < p2(k)) k--;
        m = int'((v / p2(k) - 1.0) * 128.0);
        return {s, 8'(k + 127), 7'(m)};
    endfunction

    function automatic logic [15:0] rand_bf16(int emin, int emax);
        logic [15:0] r;
        r[15]   = 1'($urandom % 2);
        r[14:7] = 8'(emin + int'($urandom % 32'(emax - emin + 1)));
        r[6:0]  = 7'($urandom);
        return r;
    endfunction

    // Independent model: real-valued max, scale search, nearest-code search.
    task automatic load_expect();
        real mx = 0.0;
        int  t;
        for (int i = 0; i < TILE; i++) begin
            real a = bf16_val(tile_in[i]);
            if (a < 0.0) a = -a;
            if (a > mx) mx = a;
        end
        if (mx == 0.0) t = 0;
        else begin
            t = -200;
            while (mx > 448.0 * p2(t)) t++;
        end
        for (int i = 0; i < TILE; i++) begin
            real a = bf16_val(tile_in[i]);
            real bd;
            int  best = 0;
            if (a < 0.0) a = -a;
            a  = a / p2(t);
            bd = a;
            for (int c = 1; c < 127; c++) begin
                real d = a - code_val(7'(c));
                if (d < 0.0) d = -d;
                if (d < bd || (d == bd && (c % 2) == 0)) begin
                    bd = d;
                    best = c;
                end
            end
            exp_code[exp_wr]  = {tile_in[i][15], 7'(best)};
            exp_scale[exp_wr] = t;
            exp_wr++;
        end
    endtask

    // Output side: drive out_ready at negedge, check accepted codes.
    always @(negedge clk) begin
        out_ready <= rdy_random ? (($urandom % 3) != 0) : 1'b1;
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_rd >= exp_wr) begin
                chk(1'b0, "R9", "unexpected output", int'(out_code), -1);
            end else begin
                chk(out_code == exp_code[exp_rd], cur_req, "code",
                    int'(out_code), int'(exp_code[exp_rd]));
                chk(int'(out_scale_exp) == exp_scale[exp_rd], "R2", "scale exp",
                    int'(out_scale_exp), exp_scale[exp_rd]);
                chk(out_first == ((exp_rd % TILE) == 0), "R1", "first flag",
                    int'(out_first), int'((exp_rd % TILE) == 0));
                exp_rd++;
            end
        end
    end

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic feed_elem(logic [15:0] w);
        in_data  = w;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_tile();
        load_expect();
        for (int i = 0; i < TILE; i++) feed_elem(tile_in[i]);
    endtask

    task automatic wait_drain();
        while (exp_rd < exp_wr) @(negedge clk);
    endtask

    task automatic t_reset_first();
        cur_req = "R3";
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
        for (int i = 0; i < TILE; i++) tile_in[i] = rand_bf16(110, 140);
        load_expect();
        for (int i = 0; i < TILE - 1; i++) feed_elem(tile_in[i]);
        chk(out_valid == 1'b0, "R9", "valid before tile complete", int'(out_valid), 0);
        feed_elem(tile_in[TILE-1]);
        wait_drain();
    endtask

    task automatic t_zero_tile();
        cur_req = "R6";
        for (int i = 0; i < TILE; i++) tile_in[i] = (i % 2) ? 16'h8000 : 16'h0000;
        push_tile();
        wait_drain();
        chk(exp_scale[exp_wr-1] == 0, "R6", "model scale of zero tile", exp_scale[exp_wr-1], 0);
    endtask

    task automatic t_subnormal_in();
        cur_req = "R7";
        for (int i = 0; i < TILE; i++) tile_in[i] = {1'(i % 2), 8'd0, 7'(i | 1)};
        push_tile();
        for (int i = 0; i < TILE; i++) tile_in[i] = {1'(i % 2), 8'd0, 7'h7F};
        tile_in[5] = 16'h3F80;   // 1.0 sets T = -8
        push_tile();
        wait_drain();
    endtask

    task automatic t_on_grid();
        int base = exp_wr;
        cur_req = "R8";
        tile_in[0] = grid_bf16(448.0 * p2(5), 1'b0);
        for (int i = 1; i < TILE; i++)
            tile_in[i] = grid_bf16(code_val(7'(i - 1)) * p2(5), 1'($urandom % 2));
        load_expect();
        exp_code[base] = 8'h7E;
        for (int i = 1; i < TILE; i++) begin
            exp_code[base + i]  = {tile_in[i][15], 7'(i - 1)};
            exp_scale[base + i] = 5;
        end
        exp_scale[base] = 5;
        for (int i = 0; i < TILE; i++) feed_elem(tile_in[i]);
        wait_drain();
    endtask

    task automatic t_ties();
        cur_req = "R3";
        tile_in[0] = 16'h43E0;   // 448.0 -> T = 0
        for (int i = 1; i < TILE; i++) begin
            tile_in[i] = rand_bf16(110, 134);
            tile_in[i][3:0] = 4'b1000;   // exact halfway for normal results
        end
        push_tile();
        wait_drain();
    endtask

    task automatic t_small_range();
        cur_req = "R4";
        tile_in[0] = 16'h3F80;   // 1.0 -> T = -8
        for (int i = 1; i < TILE; i++) tile_in[i] = rand_bf16(95, 116);
        push_tile();
        wait_drain();
    endtask

    task automatic t_extremes();
        cur_req = "R2";
        for (int i = 0; i < TILE; i++) tile_in[i] = rand_bf16(200, 253);
        tile_in[7] = 16'h7F7F;   // largest finite -> T = 120
        push_tile();
        for (int i = 0; i < TILE; i++) tile_in[i] = {1'(i % 2), 8'd0, 7'd3};
        tile_in[9] = 16'h0080;   // smallest normal -> T = -134
        push_tile();
        wait_drain();
        chk(exp_scale[exp_wr-TILE-1] == 120, "R2", "model top scale", exp_scale[exp_wr-TILE-1], 120);
    endtask

    task automatic t_throughput();
        cur_req = "R10";
        rdy_random = 1'b0;
        stall_cnt  = 0;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < TILE; i++) tile_in[i] = rand_bf16(60, 200);
            push_tile();
        end
        chk(stall_cnt == 0, "R10", "input stalls with free output", stall_cnt, 0);
        wait_drain();
    endtask

    task automatic t_backpressure();
        cur_req = "R11";
        rdy_random = 1'b1;
        stall_cnt  = 0;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < TILE; i++) tile_in[i] = rand_bf16(120, 135);
            push_tile();
        end
        wait_drain();
        chk(stall_cnt > 0, "R11", "input stalls when buffers full", stall_cnt, 1);
        rdy_random = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "idle after all tiles", int'(out_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_first();
        t_zero_tile();
        t_subnormal_in();
        t_on_grid();
        t_ties();
        t_small_range();
        t_extremes();
        t_throughput();
        t_backpressure();
        chk(exp_rd == exp_wr, "R1", "codes received", exp_rd, exp_wr);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule